// File: doc/BRIEF.md
# KCS Message Exchange Engine

This block is the management-controller side of a keyboard-controller-style (KCS) IPMI channel. A host-bus front end, which is outside the block, reports every host write with a one-cycle event. The event carries the written byte and a flag that says whether the host wrote the command port or the data port. The engine runs the write-then-read message phases. It keeps request bytes in a small buffer. When the request ends, it forms a reply from a built-in responder. It then feeds the reply back one byte per host read request. Each event produces exactly one load of the output data register and an update of the two-bit state field that the host polls.

The responder echoes the first two request bytes, which are the network function and the command, and then adds a completion code. Two requests in the application class are answered with a fixed payload. Every other request receives an "invalid command" code. The engine also carries out the two-step status/abort handshake, overflow protection on the request buffer and forced-abort recovery for illegal traffic. `REQ_DEPTH` must be at least 2 and `DEVID_LEN` at least 2.

Top module: `kcs_xfer_engine`

## Requirements
- R1: While reset is held, and after it is released, `state_o` is 0, `odr_o` is 0x00 and `odr_wr_o` is 0.
- R2: For each cycle with `ibf_i` high, `odr_wr_o` is high on the following cycle together with the new `odr_o`/`state_o`. A cycle without an event leaves `odr_wr_o` low and holds `odr_o` and `state_o`.
- R3: The state field is encoded as 0 idle, 1 read, 2 write and 3 error. Every command byte (`cod_i`=1) first gives state 2 and output 0x00. Code 0x61 then starts a new request: it clears the stored length, the reply index and the pending error.
- R4: After 0x61, each data byte is stored in order. It leaves state 2 and outputs 0x00.
- R5: After code 0x62, the next data byte is the final request byte. It gives state 1 and outputs reply byte 0.
- R6: The reply consists of the first request byte, the second request byte and a completion code. A request byte that was never sent counts as 0x00. When bits [7:2] of byte 0 equal 6 and byte 1 is 0x01, the code is 0x00 and is followed by the `DEVID_LEN`-byte `DEVID_DATA`, most significant byte first. When those bits equal 6 and byte 1 is 0x04, the code is 0x00 and is followed by the two bytes of `SELFTEST_DATA`. Any other request gets 0xC1 alone. Each data byte 0x68 in the read phase outputs the next reply byte with state 1.
- R7: A 0x68 that arrives after the last reply byte has been output gives state 0 and output 0x00, and the engine returns to idle.
- R8: In the read phase, a data byte other than 0x68 gives state 3 and output 0x00. It does not advance the reply index.
- R9: Code 0x60 records error 0x01. The next data byte gives state 1 and outputs 0x01. The data byte after that gives state 0 and outputs 0x00.
- R10: A data byte that arrives in the write phases when `REQ_DEPTH` bytes are already stored records error 0x06 and forces an abort. A forced abort gives state 3 and output 0x00. While any error is pending, code 0x62 also forces an abort.
- R11: An undefined command code records error 0x02 and forces an abort. A data byte that arrives in the idle or error phase forces an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ibf_i | input | 1 | One-cycle host-write event |
| cod_i | input | 1 | 1: byte written to command port, 0: data port |
| din_i | input | 8 | Byte written by the host |
| odr_o | output | 8 | Output data register |
| odr_wr_o | output | 1 | Output register loaded on previous edge |
| state_o | output | 2 | KCS state field (0 idle, 1 read, 2 write, 3 error) |

## Verification
The bench targets four corner cases:
- **One-byte requests.** The final byte is also byte 0. A design that read the buffer before storing that byte would return a stale network function, and a design that left the command byte undefined would pick the wrong reply.
- **Request overflow.** A request one byte longer than the buffer must abort. A design that failed to abort would wrap the index and corrupt byte 0, and a design that forgot the pending error would accept the following 0x62.
- **Bad read bytes.** A wrong byte in the read phase must not consume a reply byte. A design that did would skip data on the next 0x68.
- **Aborts.** Aborts are mixed into the middle of replies. A design that failed to keep error 0x01 would return the wrong status byte.

// File: rtl/kcs_xfer_engine.sv
module kcs_xfer_engine #(
  parameter int REQ_DEPTH = 16,
  parameter int DEVID_LEN = 15,
  parameter logic [8*DEVID_LEN-1:0] DEVID_DATA = 120'h20_01_01_00_02_BF_00_00_00_10_00_01_00_00_00,
  parameter logic [15:0] SELFTEST_DATA = 16'h55_00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ibf_i,
  input  logic       cod_i,
  input  logic [7:0] din_i,
  output logic [7:0] odr_o,
  output logic       odr_wr_o,
  output logic [1:0] state_o
);

  localparam int CW = $clog2(REQ_DEPTH + 1);
  localparam int AW = $clog2(REQ_DEPTH);
  localparam int RLEN_MAX = 3 + DEVID_LEN;
  localparam int RW = $clog2(RLEN_MAX + 1);

  localparam logic [7:0] C_ABORT  = 8'h60;
  localparam logic [7:0] C_WSTART = 8'h61;
  localparam logic [7:0] C_WEND   = 8'h62;
  localparam logic [7:0] C_READ   = 8'h68;

  localparam logic [7:0] E_NONE    = 8'h00;
  localparam logic [7:0] E_ABORT   = 8'h01;
  localparam logic [7:0] E_ILLEGAL = 8'h02;
  localparam logic [7:0] E_LENGTH  = 8'h06;

  localparam logic [1:0] ST_IDLE  = 2'd0;
  localparam logic [1:0] ST_READ  = 2'd1;
  localparam logic [1:0] ST_WRITE = 2'd2;
  localparam logic [1:0] ST_ERROR = 2'd3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_WSTART, PH_WDATA, PH_WEND, PH_READ, PH_ABT1, PH_ABT2, PH_ERR
  } phase_t;

  phase_t        ph_q;
  logic [7:0]    req_mem [REQ_DEPTH];
  logic [CW-1:0] req_cnt;
  logic [RW-1:0] rsp_idx;
  logic [7:0]    err_q;

  logic          full;
  logic [7:0]    rq0, rq1, rsp_cc, rsp_b, first_b;
  logic          app, is_dev, is_st;
  logic [RW-1:0] rsp_len;

  assign full    = (req_cnt == CW'(REQ_DEPTH));
  assign rq0     = (req_cnt > CW'(0)) ? req_mem[0] : 8'h00;
  assign rq1     = (req_cnt > CW'(1)) ? req_mem[1] : 8'h00;
  assign app     = (rq0[7:2] == 6'd6);
  assign is_dev  = app && (rq1 == 8'h01);
  assign is_st   = app && (rq1 == 8'h04);
  assign rsp_cc  = (is_dev || is_st) ? 8'h00 : 8'hC1;
  assign rsp_len = is_dev ? RW'(RLEN_MAX) : (is_st ? RW'(5) : RW'(3));
  assign first_b = (req_cnt == CW'(0)) ? din_i : req_mem[0];

  always_comb begin
    int k;
    k = int'(rsp_idx) - 3;
    rsp_b = 8'h00;
    if (rsp_idx == RW'(0))      rsp_b = rq0;
    else if (rsp_idx == RW'(1)) rsp_b = rq1;
    else if (rsp_idx == RW'(2)) rsp_b = rsp_cc;
    else if (is_dev && k >= 0 && k < DEVID_LEN)
      rsp_b = DEVID_DATA[8*(DEVID_LEN-1-k) +: 8];
    else if (is_st && k >= 0 && k < 2)
      rsp_b = SELFTEST_DATA[8*(1-k) +: 8];
  end

  always_ff @(posedge clk) begin
    if (ibf_i && !cod_i && (ph_q == PH_WSTART || ph_q == PH_WDATA || ph_q == PH_WEND) && !full)
      req_mem[req_cnt[AW-1:0]] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      req_cnt  <= '0;
      rsp_idx  <= '0;
      err_q    <= E_NONE;
      odr_o    <= 8'h00;
      odr_wr_o <= 1'b0;
      state_o  <= ST_IDLE;
    end else begin
      odr_wr_o <= ibf_i;
      if (ibf_i) begin
        odr_o <= 8'h00;
        if (cod_i) begin
          state_o <= ST_WRITE;
          case (din_i)
            C_WSTART: begin
              req_cnt <= '0;
              rsp_idx <= '0;
              err_q   <= E_NONE;
              ph_q    <= PH_WSTART;
            end
            C_WEND: begin
              if (err_q != E_NONE) begin
                state_o <= ST_ERROR;
                ph_q    <= PH_ERR;
                req_cnt <= '0;
              end else begin
                ph_q <= PH_WEND;
              end
            end
            C_ABORT: begin
              err_q <= E_ABORT;
              ph_q  <= PH_ABT1;
            end
            default: begin
              err_q   <= E_ILLEGAL;
              state_o <= ST_ERROR;
              ph_q    <= PH_ERR;
              req_cnt <= '0;
            end
          endcase
        end else begin
          case (ph_q)
            PH_WSTART, PH_WDATA, PH_WEND: begin
              if (full) begin
                err_q   <= E_LENGTH;
                state_o <= ST_ERROR;
                ph_q    <= PH_ERR;
                req_cnt <= '0;
              end else if (ph_q == PH_WEND) begin
                req_cnt <= req_cnt + CW'(1);
                state_o <= ST_READ;
                odr_o   <= first_b;
                rsp_idx <= RW'(1);
                ph_q    <= PH_READ;
              end else begin
                req_cnt <= req_cnt + CW'(1);
                state_o <= ST_WRITE;
                ph_q    <= PH_WDATA;
              end
            end
            PH_READ: begin
              if (din_i != C_READ) begin
                state_o <= ST_ERROR;
              end else if (rsp_idx == rsp_len) begin
                state_o <= ST_IDLE;
                ph_q    <= PH_IDLE;
              end else begin
                state_o <= ST_READ;
                odr_o   <= rsp_b;
                rsp_idx <= rsp_idx + RW'(1);
              end
            end
            PH_ABT1: begin
              state_o <= ST_READ;
              odr_o   <= err_q;
              ph_q    <= PH_ABT2;
            end
            PH_ABT2: begin
              state_o <= ST_IDLE;
              ph_q    <= PH_IDLE;
            end
            default: begin
              state_o <= ST_ERROR;
              ph_q    <= PH_ERR;
              req_cnt <= '0;
            end
          endcase
        end
      end
    end
  end

  // R2
  odr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ibf_i |=> odr_wr_o);

  // R2
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ibf_i |=> (!odr_wr_o && $stable(odr_o) && $stable(state_o)));

  // R3
  cmd_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf_i && cod_i) |=> (state_o == ST_WRITE || state_o == ST_ERROR));

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_cnt <= CW'(REQ_DEPTH));

  // R8
  bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf_i && !cod_i && ph_q == PH_READ && din_i != C_READ)
      |=> (state_o == ST_ERROR && odr_o == 8'h00 && $stable(rsp_idx)));

  // R9
  abort_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf_i && !cod_i && ph_q == PH_ABT1) |=> (state_o == ST_READ && odr_o == $past(err_q)));

endmodule

// File: tb/test_kcs_xfer_engine.sv
`timescale 1ns/1ps
module test_kcs_xfer_engine;
  localparam int DEPTH = 16;
  localparam int DLEN = 15;
  localparam logic [8*DLEN-1:0] DEVID = 120'h20_01_01_00_02_BF_00_00_00_10_00_01_00_00_00;
  localparam logic [15:0] SELFT = 16'h55_00;

  logic clk = 0, rst_n = 0, ibf = 0, cod = 0;
  logic [7:0] din = 0;
  logic [7:0] odr;
  logic odr_wr;
  logic [1:0] st;

  kcs_xfer_engine i_kcs_xfer_engine (
    .clk(clk), .rst_n(rst_n), .ibf_i(ibf), .cod_i(cod), .din_i(din),
    .odr_o(odr), .odr_wr_o(odr_wr), .state_o(st));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m_ph = 0;
  int m_cnt = 0, m_ridx = 0;
  logic [7:0] m_err = 0;
  logic [7:0] m_req [DEPTH];
  logic [7:0] e_odr = 0;
  logic [1:0] e_st = 0;
  string tag;

  function automatic logic [7:0] rq(int i);
    return (m_cnt > i) ? m_req[i] : 8'h00;
  endfunction

  function automatic int rlen();
    if (rq(0)[7:2] == 6'd6 && rq(1) == 8'h01) return 3 + DLEN;
    if (rq(0)[7:2] == 6'd6 && rq(1) == 8'h04) return 5;
    return 3;
  endfunction

  function automatic logic [7:0] rbyte(int i);
    int n = rlen();
    if (i == 0) return rq(0);
    if (i == 1) return rq(1);
    if (i == 2) return (n > 3) ? 8'h00 : 8'hC1;
    if (n == 3 + DLEN) return DEVID[8*(DLEN-1-(i-3)) +: 8];
    return SELFT[8*(1-(i-3)) +: 8];
  endfunction

  task automatic fabort();
    e_st = 3; e_odr = 0; m_ph = 7; m_cnt = 0;
  endtask

  task automatic model(bit c, logic [7:0] d);
    e_odr = 0;
    if (c) begin
      e_st = 2;
      case (d)
        8'h61: begin m_cnt = 0; m_ridx = 0; m_err = 0; m_ph = 1; tag = "R3"; end
        8'h62: if (m_err != 0) begin fabort(); tag = "R10"; end else begin m_ph = 3; tag = "R5"; end
        8'h60: begin m_err = 1; m_ph = 5; tag = "R9"; end
        default: begin m_err = 2; fabort(); tag = "R11"; end
      endcase
    end else begin
      case (m_ph)
        1, 2, 3: begin
          if (m_cnt == DEPTH) begin m_err = 6; fabort(); tag = "R10"; end
          else begin
            m_req[m_cnt] = d; m_cnt++;
            if (m_ph == 3) begin e_st = 1; e_odr = rbyte(0); m_ridx = 1; m_ph = 4; tag = "R5"; end
            else begin e_st = 2; m_ph = 2; tag = "R4"; end
          end
        end
        4: begin
          if (d != 8'h68) begin e_st = 3; tag = "R8"; end
          else if (m_ridx == rlen()) begin e_st = 0; m_ph = 0; tag = "R7"; end
          else begin e_st = 1; e_odr = rbyte(m_ridx); m_ridx++; tag = "R6"; end
        end
        5: begin e_st = 1; e_odr = m_err; m_ph = 6; tag = "R9"; end
        6: begin e_st = 0; m_ph = 0; tag = "R9"; end
        default: begin fabort(); tag = "R11"; end
      endcase
    end
  endtask

  task automatic check(bit ok, string t);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: odr=%h wr=%0d state=%0d expected odr=%h wr=1 state=%0d", t, odr, odr_wr, st, e_odr, e_st);
    end
  endtask

  task automatic send(bit c, logic [7:0] d);
    @(negedge clk); ibf = 1; cod = c; din = d;
    model(c, d);
    @(negedge clk); ibf = 0;
    check(odr_wr && odr == e_odr && st == e_st, tag);
  endtask

  task automatic quiet();
    @(negedge clk);
    n_chk++;
    if (odr_wr || odr != e_odr || st != e_st) begin
      n_bad++;
      $display("FAIL R2: idle odr=%h wr=%0d state=%0d expected odr=%h wr=0 state=%0d", odr, odr_wr, st, e_odr, e_st);
    end
  endtask

  task automatic request(logic [7:0] b [], int len);
    send(1, 8'h61);
    for (int i = 0; i < len - 1; i++) send(0, b[i]);
    send(1, 8'h62);
    send(0, b[len-1]);
  endtask

  task automatic drain();
    for (int i = 0; i < 24 && m_ph == 4; i++) send(0, 8'h68);
  endtask

  logic [7:0] buf8 [];

  initial begin
    buf8 = new[DEPTH + 2];
    repeat (3) @(negedge clk);
    n_chk++;
    if (odr_wr || odr != 0 || st != 0) begin
      n_bad++; $display("FAIL R1: odr=%h wr=%0d state=%0d expected 00/0/0", odr, odr_wr, st);
    end
    rst_n = 1;
    quiet();

    buf8[0] = 8'h18; buf8[1] = 8'h01; buf8[2] = 8'hAA;   // R6 device payload, extra byte
    request(buf8, 3); drain(); quiet();
    buf8[0] = 8'h1B; buf8[1] = 8'h04;                    // R6 self-test
    request(buf8, 2); drain();
    buf8[0] = 8'h0C; buf8[1] = 8'h01;                    // R6 invalid
    request(buf8, 2); drain();
    buf8[0] = 8'h18;                                     // R5 single byte request
    request(buf8, 1); drain();
    buf8[0] = 8'h18; buf8[1] = 8'h04;                    // R8 bad read byte, no advance
    request(buf8, 2); send(0, 8'h11); send(0, 8'h11); drain();
    send(1, 8'h60); send(0, 8'h00); send(0, 8'h00);      // R9 abort handshake
    for (int i = 0; i < DEPTH + 1; i++) buf8[i] = 8'(i + 8'h18);
    request(buf8, DEPTH + 1);                            // R10 overflow at final byte
    send(1, 8'h61);
    for (int i = 0; i < DEPTH + 1; i++) send(0, 8'h33);  // R10 overflow in data
    send(1, 8'h62);                                      // R10 pending error
    send(1, 8'h6A); send(0, 8'h68);                      // R11
    send(1, 8'h60); send(0, 8'h00); send(0, 8'h00);
    send(0, 8'h05);                                      // R11 data in idle
    send(1, 8'h62);                                      // R10 error still pending

    void'($urandom(32'd1234));
    for (int t = 0; t < 300; t++) begin
      int len = 1 + int'($urandom_range(DEPTH + 1));
      for (int i = 0; i < len; i++) buf8[i] = 8'($urandom);
      case ($urandom_range(3))
        0: buf8[0] = 8'h18; 1: buf8[0] = 8'h1A; 2: buf8[0] = 8'h0C; default: ;
      endcase
      if (len > 1) case ($urandom_range(2)) 0: buf8[1] = 8'h01; 1: buf8[1] = 8'h04; default: ; endcase
      request(buf8, len);
      for (int i = 0; i < 24 && m_ph == 4; i++) begin
        int r = int'($urandom_range(29));
        if (r == 0) send(0, 8'($urandom));
        else if (r == 1) begin send(1, 8'h60); send(0, 8'h68); send(0, 8'h68); end
        else send(0, 8'h68);
      end
      if ($urandom_range(9) == 0) send(1, 8'h70);
      if ($urandom_range(9) == 0) send(0, 8'h68);
      if ($urandom_range(4) == 0) quiet();
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule